// File: doc/BRIEF.md
# Timer Brake and Output-Enable Controller

This block sits between the compare stage of a motor-control timer and its output pins. For every channel it takes a raw PWM level for the normal pin and one for the complementary pin. It decides, per pin pair, whether the pair follows the PWM, drives a fixed safe level, or releases both pins to high impedance. A single stored main-enable flag governs all channels. Software can set or clear the flag. Hardware can also set it again on each counter overflow, so the outputs come back on their own after a fault has gone away.

An external brake pin, with a selectable active level, can be switched in. When it is active, the effective main enable drops within the same cycle through a path that is purely combinational. The stored flag is cleared at the next edge and cannot be set again while the brake stays active. A separate copy of the brake condition passes through a flop synchronizer and sets a sticky brake flag, which software clears.

Two select inputs choose how the outputs behave when the pair is not running. One applies while the main enable is set and the timer is stopped. The other applies while the main enable is clear.

Top module: `brk_oe_ctrl`

## Requirements
- R1: A channel whose `ch_out_en` bit is 0 keeps `oe_p`, `oe_n`, `out_p` and `out_n` at 0 for that channel in every state.
- R2: A `sw_moe_set` pulse sets the main enable and a `sw_moe_clr` pulse clears it, with the result on `moe` after the next rising edge; when both are high together, clear wins.
- R3: With `auto_en` = 1, an `ovf_pulse` sets the main enable at the next edge; with `auto_en` = 0 the overflow pulse leaves it unchanged.
- R4: The brake is active when `brake_en` = 1 and `brake_in` equals `brake_pol` (0 = active low, 1 = active high). An active brake forces `moe` to 0 in the same cycle, with no clock edge, and clears the stored enable.
- R5: With `brake_en` = 0, `brake_in` has no effect on `moe` or `brake_flag`.
- R6: While the brake is active, neither `sw_moe_set` nor an automatic overflow set can raise the main enable, and `moe` stays 0 once the brake is released.
- R7: With `moe` = 1 and `timer_active` = 1, a configured channel drives both pins (`oe` = 1) with `out_p` = `pwm_p` and `out_n` = `pwm_n`.
- R8: With `moe` = 1 and `timer_active` = 0, a configured channel releases both pins (`oe` = 0, `out` = 0) when `run_idle_sel` = 0. When `run_idle_sel` = 1 it drives `inact_p` and `inact_n` with `oe` = 1.
- R9: With `moe` = 0, a configured channel releases both pins when `off_idle_sel` = 0. When `off_idle_sel` = 1 it drives `idle_p` and `idle_n` with `oe` = 1.
- R10: `brake_flag` rises SYNC_STAGES+1 rising edges after the brake becomes active (3 edges with the default of 2). It stays set until a `flag_clr` pulse arrives while the synchronized brake is inactive; a synchronized brake that is still active wins over `flag_clr`.
- R11: During and after reset, `moe` = 0, `brake_flag` = 0, and with `off_idle_sel` = 0 all output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_moe_set | input | 1 | Software pulse that sets the main enable |
| sw_moe_clr | input | 1 | Software pulse that clears the main enable |
| auto_en | input | 1 | Enables the set on overflow |
| ovf_pulse | input | 1 | Counter overflow pulse |
| brake_in | input | 1 | Raw external brake pin |
| brake_pol | input | 1 | Brake active level: 0 low, 1 high |
| brake_en | input | 1 | Switches the brake pin in |
| flag_clr | input | 1 | Software pulse that clears the brake flag |
| timer_active | input | 1 | Counter running |
| run_idle_sel | input | 1 | Policy when the main enable is set and the timer is stopped |
| off_idle_sel | input | 1 | Policy when the main enable is clear |
| ch_out_en | input | NCH | Channel configured as output |
| pwm_p | input | NCH | Raw normal-pin PWM level |
| pwm_n | input | NCH | Raw complementary-pin PWM level |
| inact_p | input | NCH | Inactive level of the normal pin |
| inact_n | input | NCH | Inactive level of the complementary pin |
| idle_p | input | NCH | Idle level of the normal pin |
| idle_n | input | NCH | Idle level of the complementary pin |
| moe | output | 1 | Effective main enable |
| brake_flag | output | 1 | Sticky brake flag |
| out_p | output | NCH | Gated normal-pin level |
| out_n | output | NCH | Gated complementary-pin level |
| oe_p | output | NCH | Normal-pin drive enable |
| oe_n | output | NCH | Complementary-pin drive enable |

## Verification
The pin gating and the brake kill are combinational, so their results are due in the same cycle. The bench samples them 1 ns after driving the inputs, with no clock edge in between. The main enable changes one rising edge after a set, clear or overflow pulse, and the brake flag changes SYNC_STAGES+1 edges after the brake condition. The bench drives every input 1 ns after a rising edge and counts edges before it samples. Around the flag it checks both the edge before the flag is due and the edge on which it is due. The gating function is swept over every per-channel input combination under each main-enable, timer-state and policy setting.

// File: rtl/brk_oe_pkg.sv
`timescale 1ns/1ps
package brk_oe_pkg;
   typedef enum logic [1:0] {
      PAIR_HIZ   = 2'd0,
      PAIR_PWM   = 2'd1,
      PAIR_INACT = 2'd2,
      PAIR_IDLE  = 2'd3
   } pair_mode_e;

   function automatic pair_mode_e pick_mode(input logic cfg, input logic en,
                                            input logic run, input logic rsel,
                                            input logic osel);
      pair_mode_e m;
      if (!cfg)              m = PAIR_HIZ;
      else if (en && run)    m = PAIR_PWM;
      else if (en)           m = rsel ? PAIR_INACT : PAIR_HIZ;
      else                   m = osel ? PAIR_IDLE : PAIR_HIZ;
      return m;
   endfunction
endpackage

// File: rtl/brk_oe_sync.sv
`timescale 1ns/1ps
module brk_oe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("brk_oe_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/brk_oe_state.sv
`timescale 1ns/1ps
module brk_oe_state (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_set,
   input  logic sw_clr,
   input  logic auto_en,
   input  logic ovf,
   input  logic brk_now,
   input  logic brk_sync,
   input  logic flag_clr,
   output logic moe,
   output logic flag
);
   logic moe_q;
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         moe_q  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (brk_now)                          moe_q <= 1'b0;
         else if (sw_clr)                      moe_q <= 1'b0;
         else if (sw_set || (auto_en && ovf))  moe_q <= 1'b1;

         if (brk_sync)      flag_q <= 1'b1;
         else if (flag_clr) flag_q <= 1'b0;
      end
   end

   assign moe  = moe_q & ~brk_now;
   assign flag = flag_q;
endmodule

// File: rtl/brk_oe_gate.sv
`timescale 1ns/1ps
module brk_oe_gate
   import brk_oe_pkg::*;
(
   input  logic cfg,
   input  logic en,
   input  logic run,
   input  logic rsel,
   input  logic osel,
   input  logic pwm_p,
   input  logic pwm_n,
   input  logic inact_p,
   input  logic inact_n,
   input  logic idle_p,
   input  logic idle_n,
   output logic op,
   output logic on,
   output logic ep,
   output logic en_n
);
   pair_mode_e mode;

   always_comb begin
      mode = pick_mode(cfg, en, run, rsel, osel);
      op   = 1'b0;
      on   = 1'b0;
      ep   = 1'b0;
      en_n = 1'b0;
      case (mode)
         PAIR_PWM:   begin op = pwm_p;   on = pwm_n;   ep = 1'b1; en_n = 1'b1; end
         PAIR_INACT: begin op = inact_p; on = inact_n; ep = 1'b1; en_n = 1'b1; end
         PAIR_IDLE:  begin op = idle_p;  on = idle_n;  ep = 1'b1; en_n = 1'b1; end
         default:    begin op = 1'b0;    on = 1'b0;    ep = 1'b0; en_n = 1'b0; end
      endcase
   end
endmodule

// File: rtl/brk_oe_ctrl.sv
`timescale 1ns/1ps
module brk_oe_ctrl #(
   parameter int NCH         = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sw_moe_set,
   input  logic           sw_moe_clr,
   input  logic           auto_en,
   input  logic           ovf_pulse,
   input  logic           brake_in,
   input  logic           brake_pol,
   input  logic           brake_en,
   input  logic           flag_clr,
   input  logic           timer_active,
   input  logic           run_idle_sel,
   input  logic           off_idle_sel,
   input  logic [NCH-1:0] ch_out_en,
   input  logic [NCH-1:0] pwm_p,
   input  logic [NCH-1:0] pwm_n,
   input  logic [NCH-1:0] inact_p,
   input  logic [NCH-1:0] inact_n,
   input  logic [NCH-1:0] idle_p,
   input  logic [NCH-1:0] idle_n,
   output logic           moe,
   output logic           brake_flag,
   output logic [NCH-1:0] out_p,
   output logic [NCH-1:0] out_n,
   output logic [NCH-1:0] oe_p,
   output logic [NCH-1:0] oe_n
);
   logic brk_now;
   logic brk_sync;
   logic moe_eff;

   generate
      if (NCH < 1) begin : g_bad_nch
         $error("brk_oe_ctrl: NCH must be at least 1");
      end
   endgenerate

   // Kill path: no register between pin and enable.
   assign brk_now = brake_en & (brake_in ~^ brake_pol);

   brk_oe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (brk_now),
      .q     (brk_sync)
   );

   brk_oe_state u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_set   (sw_moe_set),
      .sw_clr   (sw_moe_clr),
      .auto_en  (auto_en),
      .ovf      (ovf_pulse),
      .brk_now  (brk_now),
      .brk_sync (brk_sync),
      .flag_clr (flag_clr),
      .moe      (moe_eff),
      .flag     (brake_flag)
   );

   assign moe = moe_eff;

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         brk_oe_gate u_gate (
            .cfg     (ch_out_en[i]),
            .en      (moe_eff),
            .run     (timer_active),
            .rsel    (run_idle_sel),
            .osel    (off_idle_sel),
            .pwm_p   (pwm_p[i]),
            .pwm_n   (pwm_n[i]),
            .inact_p (inact_p[i]),
            .inact_n (inact_n[i]),
            .idle_p  (idle_p[i]),
            .idle_n  (idle_n[i]),
            .op      (out_p[i]),
            .on      (out_n[i]),
            .ep      (oe_p[i]),
            .en_n    (oe_n[i])
         );
      end
   endgenerate
endmodule

// File: rtl/brk_oe_chk.sv
`timescale 1ns/1ps
module brk_oe_chk #(
   parameter int NCH = 3
) (
   input logic           clk,
   input logic           rst_n,
   input logic           sw_moe_set,
   input logic           sw_moe_clr,
   input logic           auto_en,
   input logic           ovf_pulse,
   input logic           brake_in,
   input logic           brake_pol,
   input logic           brake_en,
   input logic           flag_clr,
   input logic           timer_active,
   input logic           off_idle_sel,
   input logic [NCH-1:0] ch_out_en,
   input logic [NCH-1:0] pwm_p,
   input logic [NCH-1:0] pwm_n,
   input logic           moe,
   input logic           brake_flag,
   input logic [NCH-1:0] out_p,
   input logic [NCH-1:0] out_n,
   input logic [NCH-1:0] oe_p,
   input logic [NCH-1:0] oe_n
);
   logic pin_hit;
   assign pin_hit = brake_en && (brake_in == brake_pol);

   AST_BRAKE_KILL: assert property (@(posedge clk) disable iff (!rst_n)
      pin_hit |-> !moe);                                                   // R4
   AST_BRAKE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      pin_hit |=> !moe);                                                   // R6
   AST_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_moe_set && !sw_moe_clr && !pin_hit) |=> (moe || pin_hit));       // R2
   AST_SW_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      sw_moe_clr |=> !moe);                                                // R2
   AST_AUTO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && ovf_pulse && !sw_moe_clr && !pin_hit) |=> (moe || pin_hit)); // R3
   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (brake_flag && !flag_clr) |=> brake_flag);                           // R10
   AST_RUN_PWM: assert property (@(posedge clk) disable iff (!rst_n)
      (moe && timer_active) |-> (oe_p == ch_out_en && oe_n == ch_out_en &&
       out_p == (pwm_p & ch_out_en) && out_n == (pwm_n & ch_out_en)));    // R7
   AST_OFF_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (!moe && !off_idle_sel) |-> (oe_p == '0 && oe_n == '0));             // R9

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_uncfg
         AST_UNCFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_out_en[i] |-> (!oe_p[i] && !oe_n[i] && !out_p[i] && !out_n[i])); // R1
      end
   endgenerate
endmodule

bind brk_oe_ctrl brk_oe_chk #(.NCH(NCH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sw_moe_set   (sw_moe_set),
   .sw_moe_clr   (sw_moe_clr),
   .auto_en      (auto_en),
   .ovf_pulse    (ovf_pulse),
   .brake_in     (brake_in),
   .brake_pol    (brake_pol),
   .brake_en     (brake_en),
   .flag_clr     (flag_clr),
   .timer_active (timer_active),
   .off_idle_sel (off_idle_sel),
   .ch_out_en    (ch_out_en),
   .pwm_p        (pwm_p),
   .pwm_n        (pwm_n),
   .moe          (moe),
   .brake_flag   (brake_flag),
   .out_p        (out_p),
   .out_n        (out_n),
   .oe_p         (oe_p),
   .oe_n         (oe_n)
);

// File: tb/tb_brk_oe_ctrl.sv
`timescale 1ns/1ps
module tb_brk_oe_ctrl;
   localparam int NCH = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sw_moe_set = 0, sw_moe_clr = 0, auto_en = 0, ovf_pulse = 0;
   logic brake_in = 0, brake_pol = 0, brake_en = 0, flag_clr = 0;
   logic timer_active = 0, run_idle_sel = 0, off_idle_sel = 0;
   logic [NCH-1:0] ch_out_en = '0, pwm_p = '0, pwm_n = '0;
   logic [NCH-1:0] inact_p = '0, inact_n = '0, idle_p = '0, idle_n = '0;
   logic moe, brake_flag;
   logic [NCH-1:0] out_p, out_n, oe_p, oe_n;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   brk_oe_ctrl #(.NCH(NCH), .SYNC_STAGES(2)) dut (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic pulse_set();
      sw_moe_set = 1; tick(); sw_moe_set = 0;
   endtask

   // b: [0]cfg [1]pwm_p [2]pwm_n [3]inact_p [4]inact_n [5]idle_p [6]idle_n
   // returns {out_p, out_n, oe_p, oe_n}
   function automatic logic [3:0] exp_pair(input logic m, input logic ta,
                                           input logic rs, input logic os,
                                           input logic [6:0] b);
      if (!b[0])      return 4'b0000;
      if (m && ta)    return {b[1], b[2], 2'b11};
      if (m)          return rs ? {b[3], b[4], 2'b11} : 4'b0000;
      return os ? {b[5], b[6], 2'b11} : 4'b0000;
   endfunction

   initial begin
      ch_out_en = '1;
      repeat (3) @(posedge clk);
      #1;
      check("R11 moe in reset", moe, 0);
      check("R11 flag in reset", brake_flag, 0);
      check("R11 oe in reset", {oe_p, oe_n}, 0);
      rst_n = 1;
      tick();
      check("R11 moe after reset", moe, 0);
      check("R11 oe after reset", {oe_p, oe_n}, 0);

      // Gating sweep: R1 R7 R8 R9
      for (int m = 0; m < 2; m++) begin
         if (m == 1) sw_moe_set = 1; else sw_moe_clr = 1;
         tick();
         sw_moe_set = 0; sw_moe_clr = 0;
         check("R2 moe for sweep", moe, m);
         for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < 128; k++) begin
               logic [4*NCH-1:0] expv;
               logic [3:0] e;
               timer_active = c[0]; run_idle_sel = c[1]; off_idle_sel = c[2];
               for (int i = 0; i < NCH; i++) begin
                  logic [6:0] b;
                  b = 7'((k + 41 * i) % 128);
                  ch_out_en[i] = b[0]; pwm_p[i] = b[1]; pwm_n[i] = b[2];
                  inact_p[i] = b[3]; inact_n[i] = b[4]; idle_p[i] = b[5]; idle_n[i] = b[6];
                  e = exp_pair(m[0], c[0], c[1], c[2], b);
                  expv[i] = e[3]; expv[NCH+i] = e[2];
                  expv[2*NCH+i] = e[1]; expv[3*NCH+i] = e[0];
               end
               #1;
               if (!ch_out_en[0])
                  check("R1 unconfigured pair", {out_p[0], out_n[0], oe_p[0], oe_n[0]}, 0);
               else if (m == 1 && c[0])
                  check("R7 running pair", {oe_n, oe_p, out_n, out_p}, expv);
               else if (m == 1)
                  check("R8 stopped pair", {oe_n, oe_p, out_n, out_p}, expv);
               else
                  check("R9 disabled pair", {oe_n, oe_p, out_n, out_p}, expv);
            end
         end
      end

      // Brake polarity sweep: R4
      timer_active = 1; ch_out_en = '1; off_idle_sel = 0; run_idle_sel = 0;
      for (int pol = 0; pol < 2; pol++) begin
         for (int pin = 0; pin < 2; pin++) begin
            brake_en = 0;
            tick();
            pulse_set();
            check("R4 moe armed", moe, 1);
            brake_pol = pol[0]; brake_in = pin[0]; brake_en = 1;
            #1;
            check("R4 same-cycle kill", moe, (pin == pol) ? 0 : 1);
            check("R4 outputs follow kill", oe_p, (pin == pol) ? 0 : 3'b111);
            tick();
            check("R4 stored enable", moe, (pin == pol) ? 0 : 1);
         end
      end
      brake_en = 0;
      repeat (4) tick();
      check("R10 flag sticky after sweep", brake_flag, 1);
      flag_clr = 1; tick(); flag_clr = 0;
      check("R10 flag cleared", brake_flag, 0);

      // R5: brake ignored when disabled
      brake_pol = 1; brake_in = 1; brake_en = 0;
      pulse_set();
      repeat (4) tick();
      check("R5 moe unaffected", moe, 1);
      check("R5 flag unaffected", brake_flag, 0);

      // R10 latency and R6 blocking
      brake_en = 1;
      #1;
      check("R4 kill on enable", moe, 0);
      tick(); tick();
      check("R10 flag not yet", brake_flag, 0);
      tick();
      check("R10 flag due", brake_flag, 1);
      flag_clr = 1; tick(); flag_clr = 0;
      check("R10 set beats clear", brake_flag, 1);
      pulse_set();
      check("R6 sw set blocked", moe, 0);
      auto_en = 1; ovf_pulse = 1; tick(); ovf_pulse = 0;
      check("R6 auto set blocked", moe, 0);
      brake_in = 0;
      #1;
      check("R6 stays off on release", moe, 0);
      repeat (3) tick();
      check("R10 flag held", brake_flag, 1);
      flag_clr = 1; tick(); flag_clr = 0;
      check("R10 flag cleared by software", brake_flag, 0);

      // R3 / R2
      ovf_pulse = 1; tick(); ovf_pulse = 0;
      check("R3 auto re-arm", moe, 1);
      sw_moe_clr = 1; tick(); sw_moe_clr = 0;
      check("R2 software clear", moe, 0);
      auto_en = 0; ovf_pulse = 1; tick(); ovf_pulse = 0;
      check("R3 overflow ignored", moe, 0);
      sw_moe_set = 1; sw_moe_clr = 1; tick(); sw_moe_set = 0; sw_moe_clr = 0;
      check("R2 clear wins", moe, 0);

      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule